// File: doc/BRIEF.md
# Dual-Master Configuration Register Bridge

This block holds a small file of byte-wide configuration registers that two masters can reach. One master is a serial host on a four-wire SPI slave port, clocked by its own serial clock, which has no phase relationship to the core clock. The other is a single-cycle bus slave port with a cycle/strobe/acknowledge handshake in the core clock domain. Both masters address the same bytes.

Each time the serial side is about to read or write a register byte, it opens a short status window, one for reads and one for writes. The two windows pass through a two-flop synchroniser into the core domain. While either synchronised window is open, the bus side withholds its acknowledge, so the bus master waits. Outside those windows the bus runs at full rate, even in the middle of a serial frame. When a collision slips through the synchroniser, the bus access still completes correctly. Only the serial access may lose, either by reading a stale byte or by dropping a write. With a serial clock far below the core clock, no collision occurs.

A serial frame is a command byte, then an address byte, then any number of data bytes. The address advances by one after every data byte. The serial port works in clock mode 0: the clock idles low, input bits are sampled on the rising edge and the output changes on the falling edge.

Top module: `spi_regbridge`

## Requirements
- R1: After reset the bus acknowledge is low, the bus read data is 0x00, the serial output enable is low, and every register reads back as 0x00.
- R2: A bus write stores `bus_wdat` in register `bus_adr`. A later bus read returns that byte on `bus_rdat`, and `bus_rdat` holds its value in every cycle without an acknowledge.
- R3: A serial frame with command byte 0x80 writes each data byte after the address byte to consecutive registers. The first data byte goes to the register named by the address byte. Bits are taken MSB first on the rising edge of `spi_sck`.
- R4: A serial frame with command byte 0x40 returns the contents of consecutive registers, starting at the address byte, MSB first on `spi_sdo`. Each bit changes on the falling edge of `spi_sck`, and the first bit is valid after the falling edge that follows the address byte.
- R5: The serial register address uses only the low four bits of the address byte. It wraps from 15 to 0 while advancing through a frame.
- R6: A command byte other than 0x80 or 0x40 leaves every register unchanged for the rest of that frame.
- R7: `spi_sdo_oe` is high while `spi_csb` is low and low while `spi_csb` is high.
- R8: While a serial read or write window is open (from the rising `spi_sck` edge that ends a register byte to the next falling edge), a pending bus request is not acknowledged. It is acknowledged within 8 core cycles after the window closes.
- R9: With `spi_csb` low and no window open, a bus request is acknowledged on the first core clock edge after it is raised.
- R10: `bus_ack` is high for exactly one cycle per accepted request and is only raised while a request was present in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| spi_csb | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, asynchronous to `clk` |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo`; the pad is high impedance when low |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Bus write enable |
| bus_adr | input | 4 | Bus register address |
| bus_wdat | input | 8 | Bus write data |
| bus_rdat | output | 8 | Bus read data, valid with `bus_ack` |
| bus_ack | output | 1 | Bus acknowledge |

## Verification
The bench writes and reads every register over the bus with a distinct byte, so a swapped address or lost bit is caught. Multi-byte serial writes and reads are run at a middle address and across the 15-to-0 boundary; these separate correct auto-increment and wrap from an address that is stuck or wrongly masked. A frame with an unknown command and an address byte with high bits set show that only defined commands and the low address bits take effect. Two bus requests issued during a serial frame compare the stall cases: one lands in the middle of a byte and must be acknowledged at once, the other lands inside a write window and must wait. The second also shows that the serial write has reached the register once the stall ends.

// File: rtl/regbridge_pkg.sv
// Shared constants and types for the dual-master register bridge.
// Assumes byte-wide registers and 8-bit serial command codes.
package regbridge_pkg;
    localparam logic [7:0] CMD_WRITE = 8'h80;
    localparam logic [7:0] CMD_READ  = 8'h40;

    typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} frame_phase_t;
    typedef enum logic [1:0] {OP_NONE, OP_WR, OP_RD} frame_op_t;
endpackage

// File: rtl/strobe_sync.sv
// Multi-stage synchroniser for a vector of level signals that change slowly
// relative to clk. Assumes each bit is glitch-free at its source.
module strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frontend.sv
// Serial slave, clocked by spi_sck in mode 0. Decodes the command/address/data
// frame and raises a write or read window from the rising edge that ends a
// register byte up to the following falling edge. Windows are built from a
// set toggle (rising edge) and a clear toggle (falling edge), so each window
// is a glitch-free XOR that the core can synchronise.
// Assumes the host gives one falling edge after the last rising edge before
// raising spi_csb. Register contents are read directly from the core array.
module spi_frontend
    import regbridge_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic               rst_n,
    input  logic               spi_csb,
    input  logic               spi_sck,
    input  logic               spi_sdi,
    output logic               spi_sdo,
    output logic               spi_sdo_oe,
    input  logic [NREG*DW-1:0] reg_flat,
    output logic               wr_win,
    output logic               rd_win,
    output logic [AW-1:0]      wr_addr,
    output logic [DW-1:0]      wr_data
);
    localparam int BCW = $clog2(DW);

    logic               frame_clr;
    logic [BCW-1:0]     bit_cnt;
    logic [DW-2:0]      shift_in;
    logic [DW-1:0]      byte_now;
    logic               byte_done;
    frame_phase_t       phase;
    frame_op_t          op;
    logic [AW-1:0]      base_addr;
    logic [AW-1:0]      byte_cnt;
    logic               wr_evt, rd_evt;
    logic               wr_set_t, wr_clr_t, rd_set_t, rd_clr_t;
    logic [AW-1:0]      rd_addr;
    logic [DW-1:0]      shift_out;

    assign frame_clr = spi_csb | ~rst_n;
    assign byte_now  = {shift_in, spi_sdi};
    assign byte_done = (bit_cnt == BCW'(DW - 1));
    assign wr_evt    = byte_done && (phase == PH_DATA) && (op == OP_WR);
    assign rd_evt    = byte_done && (op == OP_RD) && (phase != PH_CMD);

    // Frame decoder: bit counting, command and address capture; cleared by chip select.
    always_ff @(posedge spi_sck or posedge frame_clr) begin
        if (frame_clr) begin
            bit_cnt   <= '0;
            shift_in  <= '0;
            phase     <= PH_CMD;
            op        <= OP_NONE;
            base_addr <= '0;
            byte_cnt  <= '0;
        end else begin
            bit_cnt  <= bit_cnt + 1'b1;
            shift_in <= byte_now[DW-2:0];
            if (byte_done) begin
                case (phase)
                    PH_CMD: begin
                        op    <= (byte_now == CMD_WRITE) ? OP_WR :
                                 (byte_now == CMD_READ)  ? OP_RD : OP_NONE;
                        phase <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        base_addr <= byte_now[AW-1:0];
                        byte_cnt  <= '0;
                        phase     <= PH_DATA;
                    end
                    default: byte_cnt <= byte_cnt + 1'b1;
                endcase
            end
        end
    end

    // Window openers: toggle the set flags and hold the address/data for the core.
    always_ff @(posedge spi_sck or negedge rst_n) begin
        if (!rst_n) begin
            wr_set_t <= 1'b0;
            rd_set_t <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_addr  <= '0;
        end else begin
            if (wr_evt) begin
                wr_set_t <= ~wr_set_t;
                wr_addr  <= AW'(base_addr + byte_cnt);
                wr_data  <= byte_now;
            end
            if (rd_evt) begin
                rd_set_t <= ~rd_set_t;
                rd_addr  <= (phase == PH_ADDR) ? byte_now[AW-1:0]
                                               : AW'(base_addr + byte_cnt + AW'(1));
            end
        end
    end

    // Falling edge: close windows, load read data or shift the output byte.
    always_ff @(negedge spi_sck or negedge rst_n) begin
        if (!rst_n) begin
            wr_clr_t  <= 1'b0;
            rd_clr_t  <= 1'b0;
            shift_out <= '0;
        end else begin
            wr_clr_t <= wr_set_t;
            rd_clr_t <= rd_set_t;
            if (rd_win) shift_out <= reg_flat[int'(rd_addr)*DW +: DW];
            else        shift_out <= {shift_out[DW-2:0], 1'b0};
        end
    end

    assign wr_win     = wr_set_t ^ wr_clr_t;
    assign rd_win     = rd_set_t ^ rd_clr_t;
    assign spi_sdo    = shift_out[DW-1];
    assign spi_sdo_oe = ~spi_csb;
endmodule

// File: rtl/reg_core.sv
// Core-domain register array with a single-cycle bus slave. Holds off the
// acknowledge while a synchronised serial window is open, and commits a
// serial write on the rising edge of the synchronised write window.
// Assumes the serial address/data inputs are stable while the window is open.
module reg_core #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int AW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cyc,
    input  logic               bus_stb,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_adr,
    input  logic [DW-1:0]      bus_wdat,
    output logic [DW-1:0]      bus_rdat,
    output logic               bus_ack,
    input  logic               wr_win_s,
    input  logic               rd_win_s,
    input  logic [AW-1:0]      spi_wr_addr,
    input  logic [DW-1:0]      spi_wr_data,
    output logic [NREG*DW-1:0] reg_flat
);
    logic [DW-1:0] regs [NREG];
    logic          wr_win_d;
    logic          accept;
    logic          spi_commit;

    assign accept     = bus_cyc && bus_stb && !bus_ack && !(wr_win_s || rd_win_s);
    assign spi_commit = wr_win_s && !wr_win_d;

    // Bus accesses, serial write commits and the acknowledge pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            bus_ack  <= 1'b0;
            bus_rdat <= '0;
            wr_win_d <= 1'b0;
        end else begin
            wr_win_d <= wr_win_s;
            bus_ack  <= accept;
            if (accept) begin
                if (bus_we) regs[bus_adr] <= bus_wdat;
                else        bus_rdat      <= regs[bus_adr];
            end else if (spi_commit) begin
                regs[spi_wr_addr] <= spi_wr_data;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign reg_flat[g*DW +: DW] = regs[g];
    end
endmodule

// File: rtl/spi_regbridge.sv
// Top level: serial front end, window synchroniser and core register array.
// Assumes the serial clock is much slower than clk; collisions favour the bus.
module spi_regbridge #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_csb,
    input  logic          spi_sck,
    input  logic          spi_sdi,
    output logic          spi_sdo,
    output logic          spi_sdo_oe,
    input  logic          bus_cyc,
    input  logic          bus_stb,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_adr,
    input  logic [DW-1:0] bus_wdat,
    output logic [DW-1:0] bus_rdat,
    output logic          bus_ack
);
    logic [NREG*DW-1:0] reg_flat;
    logic               wr_win, rd_win;
    logic [1:0]         win_s;
    logic [AW-1:0]      spi_wr_addr;
    logic [DW-1:0]      spi_wr_data;

    spi_frontend #(.NREG(NREG), .DW(DW), .AW(AW)) u_spi (
        .rst_n(rst_n), .spi_csb(spi_csb), .spi_sck(spi_sck), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .reg_flat(reg_flat),
        .wr_win(wr_win), .rd_win(rd_win), .wr_addr(spi_wr_addr), .wr_data(spi_wr_data)
    );

    strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({rd_win, wr_win}), .sync_out(win_s)
    );

    reg_core #(.NREG(NREG), .DW(DW), .AW(AW)) u_core (
        .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
        .bus_rdat(bus_rdat), .bus_ack(bus_ack),
        .wr_win_s(win_s[0]), .rd_win_s(win_s[1]),
        .spi_wr_addr(spi_wr_addr), .spi_wr_data(spi_wr_data), .reg_flat(reg_flat)
    );
endmodule

// File: rtl/regbridge_sva.sv
// Checker for the bus handshake and the stall rule, attached by bind.
module regbridge_sva #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cyc,
    input logic          bus_stb,
    input logic          bus_ack,
    input logic [DW-1:0] bus_rdat,
    input logic [1:0]    win_s
);
    AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R10
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_cyc && bus_stb)); // R10
    AST_NO_ACK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(win_s == 2'b00)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> $stable(bus_rdat)); // R2
endmodule

bind spi_regbridge regbridge_sva #(.DW(DW)) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_ack(bus_ack), .bus_rdat(bus_rdat), .win_s(win_s)
);

// File: tb/spi_regbridge_tb.sv
// Scoreboard bench: driver tasks queue expected bytes, a monitor compares results.
module spi_regbridge_tb;
    localparam int HALF_SCK = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csb = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
    logic       spi_sdo, spi_sdo_oe;
    logic       bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
    logic [3:0] bus_adr = '0;
    logic [7:0] bus_wdat = '0;
    logic [7:0] bus_rdat;
    logic       bus_ack;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    logic [7:0] model [16];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] act_val;
    event       obs_ev;

    always #2 clk = ~clk;

    spi_regbridge u_dut (
        .clk(clk), .rst_n(rst_n), .spi_csb(spi_csb), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
        .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack)
    );

    // Monitor: pop the oldest expectation and compare it with each observed byte.
    initial forever begin
        @(obs_ev);
        compared++;
        if (exp_q.size() == 0) begin
            mismatched++;
            $display("FAIL unexpected result: actual %02h expected none", act_val);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (act_val !== e) begin
                mismatched++;
                $display("FAIL %s: actual %02h expected %02h", t, act_val, e);
            end
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic observe(input logic [7:0] v);
        act_val = v;
        ->obs_ev;
        #1;
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string t);
        expect_byte(exp, t);
        observe(act);
    endtask

    // Bus access: request at a falling clk edge, wait for ack, return cycles taken.
    task automatic bus_xfer(input logic we, input logic [3:0] a, input logic [7:0] d,
                            output logic [7:0] rd, output int cyc_n);
        @(negedge clk);
        bus_cyc = 1; bus_stb = 1; bus_we = we; bus_adr = a; bus_wdat = d;
        cyc_n = 0;
        do begin
            @(negedge clk);
            cyc_n++;
        end while (!bus_ack && cyc_n < 1000);
        rd = bus_rdat;
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] rd; int n;
        bus_xfer(1'b1, a, d, rd, n);
        model[a] = d;
    endtask

    task automatic bus_read_check(input logic [3:0] a, input string t);
        logic [7:0] rd; int n;
        expect_byte(model[a], t);
        bus_xfer(1'b0, a, 8'h00, rd, n);
        observe(rd);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_sdi = tx[i];
            #HALF_SCK;
            rx[i] = spi_sdo;
            spi_sck = 1'b1;
            #HALF_SCK;
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_start();
        spi_csb = 1'b0;
        #HALF_SCK;
    endtask

    task automatic spi_stop();
        #HALF_SCK;
        spi_csb = 1'b1;
        #HALF_SCK;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, rd;
        int n;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset values on the ports
        check({7'b0, bus_ack}, 8'h00, "R1 ack");
        check(bus_rdat, 8'h00, "R1 rdat");
        check({7'b0, spi_sdo_oe}, 8'h00, "R1 sdo_oe under reset");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        bus_read_check(4'd9, "R1 register zero");

        // R2: bus write and read back of every register
        for (int i = 0; i < 16; i++) bus_write(4'(i), 8'(8'h11 * i + 8'h05));
        for (int i = 0; i < 16; i++) bus_read_check(4'(i), "R2 bus readback");
        // R10: immediate one-cycle response with no serial activity
        bus_xfer(1'b0, 4'd3, 8'h00, rd, n);
        check(8'(n), 8'd1, "R10 ack latency");
        @(negedge clk);
        check({7'b0, bus_ack}, 8'h00, "R10 ack single pulse");

        // R7: output enable follows chip select
        spi_start();
        check({7'b0, spi_sdo_oe}, 8'h01, "R7 sdo_oe with csb low");
        // R3: serial write of three bytes from address 6
        spi_byte(8'h80, rx); spi_byte(8'h06, rx);
        spi_byte(8'hA5, rx); spi_byte(8'h3C, rx); spi_byte(8'hE1, rx);
        spi_stop();
        check({7'b0, spi_sdo_oe}, 8'h00, "R7 sdo_oe with csb high");
        model[6] = 8'hA5; model[7] = 8'h3C; model[8] = 8'hE1;
        for (int i = 5; i <= 9; i++) bus_read_check(4'(i), "R3 serial write");

        // R4 and R5: serial read across the wrap, 14,15,0
        spi_start();
        spi_byte(8'h40, rx); spi_byte(8'h0E, rx);
        for (int i = 0; i < 3; i++) begin
            expect_byte(model[(14 + i) % 16], "R4 R5 serial read");
            spi_byte(8'h00, rx);
            observe(rx);
        end
        spi_stop();

        // R5: high address bits ignored and write wraps 15 -> 0
        spi_start();
        spi_byte(8'h80, rx); spi_byte(8'hFF, rx);
        spi_byte(8'h5A, rx); spi_byte(8'hC3, rx);
        spi_stop();
        model[15] = 8'h5A; model[0] = 8'hC3;
        bus_read_check(4'd15, "R5 high bits ignored");
        bus_read_check(4'd0, "R5 write wrap");

        // R6: unknown command leaves the registers alone
        spi_start();
        spi_byte(8'h11, rx); spi_byte(8'h02, rx);
        spi_byte(8'hFE, rx); spi_byte(8'hFD, rx);
        spi_stop();
        bus_read_check(4'd2, "R6 unknown command");
        bus_read_check(4'd3, "R6 unknown command");

        // R9: bus runs mid-byte while csb is low
        spi_start();
        spi_byte(8'h80, rx); spi_byte(8'h0B, rx);
        for (int i = 7; i >= 4; i--) begin
            spi_sdi = i[0]; #HALF_SCK; spi_sck = 1; #HALF_SCK; spi_sck = 0;
        end
        bus_xfer(1'b0, 4'd1, 8'h00, rd, n);
        check(8'(n), 8'd1, "R9 no stall outside window");
        for (int i = 3; i >= 1; i--) begin
            spi_sdi = i[0]; #HALF_SCK; spi_sck = 1; #HALF_SCK; spi_sck = 0;
        end
        // data byte 8'b1010_1010: last bit 0, window opens on this rising edge
        spi_sdi = 1'b0; #HALF_SCK; spi_sck = 1'b1;
        model[11] = 8'hAA;
        repeat (10) @(negedge clk);
        // R8: request during the open write window waits for the window to close
        bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = 4'd11;
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bus_ack) n++;
        end
        check(8'(n), 8'd0, "R8 ack held in window");
        spi_sck = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_ack && n < 100);
        check(8'(n <= 8), 8'd1, "R8 ack after window");
        check(bus_rdat, model[11], "R8 R3 data after stall");
        bus_cyc = 0; bus_stb = 0;
        spi_stop();

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule